// File: doc/BRIEF.md
# Flash Program/Erase Sequencer

This block is a host-side bus master for a flash bank that shares its address and data bus with an SRAM bank. The host asks for one operation at a time: a word program, a security-ID word program, a sector erase, a block erase or a whole-chip erase. The sequencer then issues the unlock and command write cycles on the shared bus. After that it polls the addressed flash location until the part reports that it has finished, and it raises a single completion pulse. The pulse carries an error flag or a timeout flag where one applies.

Polling uses one of two methods. In the first, bit 6 is watched until it stops alternating between reads. In the second, bit 7 is compared with the value expected once the write has finished. A read can land in the same instant as the device finishes its internal operation, so a result that looks final is not taken at once. Two more reads must agree before the result is accepted. If the wait runs past a per-operation cycle budget, the sequencer writes a single reset command and reports a timeout.

While a flash operation waits, a simple request/acknowledge port lets the host reach the SRAM over the same bus. A fair slot arbiter interleaves these accesses with the flash polls. The arbiter never selects both banks in the same cycle.

Top module: `flash_op_seq`

## Requirements
- R1: A word program (op_kind 0) issues exactly four writes in this order: AAh at 5555h, 55h at 2AAAh, A0h at 5555h, then op_wdata at op_addr.
- R2: Each erase issues exactly six writes: AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then a final write. The final write is 30h at op_addr for a sector erase (op_kind 1), 50h at op_addr for a block erase (op_kind 2), and 10h at 5555h for a chip erase (op_kind 3).
- R3: A security-ID program (op_kind 4) uses the word program sequence with A5h as the third data byte. It is always polled with the toggle method, whatever poll_tgl says.
- R4: With toggle polling (poll_tgl=1), a completion candidate is two consecutive reads of op_addr that return the same bit 6.
- R5: With inverted-bit polling (poll_tgl=0), a completion candidate is a read whose bit 7 equals bit 7 of the expected word. The expected word is op_wdata for a program and FFFFh for an erase.
- R6: A candidate is accepted only after two more reads that are equal to each other and still meet the test. Otherwise polling resumes, so op_done never fires while the device is still busy.
- R7: Once completion is accepted, op_err is high together with op_done if the last read word differs from the expected word. op_err and op_tmo are never both high.
- R8: If polling lasts longer than the budget for the operation (T_PROG for a program, T_ERASE for a sector or block erase, T_CHIP for a chip erase, counted in clock cycles), the sequencer issues one write of F0h and then pulses op_done with op_tmo high.
- R9: flash_en and sram_en are never high in the same cycle. While a flash operation is busy, an SRAM request is still served and acknowledged, with read data on sram_rdata in the cycle of sram_ack.
- R10: op_start is ignored while op_busy is high, and it is also ignored when op_kind is 5, 6 or 7.
- R11: After reset, op_busy, op_done, flash_en and sram_en are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_start | input | 1 | Start the operation given by op_kind |
| op_kind | input | 3 | 0 program, 1 sector erase, 2 block erase, 3 chip erase, 4 security-ID program |
| op_addr | input | AW | Target word, sector or block address |
| op_wdata | input | DW | Word to program |
| poll_tgl | input | 1 | 1 selects toggle polling, 0 selects inverted-bit polling |
| op_busy | output | 1 | An operation is in progress |
| op_done | output | 1 | One-cycle completion pulse |
| op_err | output | 1 | Final word mismatch, valid with op_done |
| op_tmo | output | 1 | Budget exceeded, valid with op_done |
| sram_req | input | 1 | SRAM access request, held until sram_ack |
| sram_we | input | 1 | 1 for an SRAM write |
| sram_addr | input | SAW | SRAM word address |
| sram_wdata | input | DW | SRAM write data |
| sram_ack | output | 1 | SRAM access finished |
| sram_rdata | output | DW | SRAM read data, valid with sram_ack |
| bus_addr | output | AW | Shared bus address |
| bus_wdata | output | DW | Shared bus write data |
| bus_rdata | input | DW | Shared bus read data, sampled at the end of an active cycle |
| bus_we | output | 1 | Write strobe for the active cycle |
| flash_en | output | 1 | Flash bank selected this cycle |
| sram_en | output | 1 | SRAM bank selected this cycle |

## Verification
The bench builds the block with AW=21, DW=16, SAW=18 and budgets of 40, 80 and 120 cycles for program, sector/block erase and chip erase. These short budgets make the timeout path and its reset write reachable within a few hundred cycles. The device model on the bench can be set to stay busy for any number of cycles up to 255. This allows one program to outlast its budget, a chip erase to stay busy long enough for SRAM traffic to interleave, and a device that finishes before the first poll. The model can also inject a single read that falsely looks finished, close to the end of the busy period, which exercises the rejection and resumption of polling under both methods.

// File: rtl/fos_pkg.sv
// Shared types and constants for the flash operation sequencer.
// Assumes 16-bit command words whose upper byte is zero.
package fos_pkg;

    typedef enum logic [2:0] {
        OP_PROG = 3'd0,
        OP_SECT = 3'd1,
        OP_BLK  = 3'd2,
        OP_CHIP = 3'd3,
        OP_SID  = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CMD,
        S_POLL,
        S_CONF1,
        S_CONF2,
        S_RST
    } st_e;

    localparam logic [14:0] UNLK_A  = 15'h5555;
    localparam logic [14:0] UNLK_B  = 15'h2AAA;
    localparam logic [7:0]  KEY_1   = 8'hAA;
    localparam logic [7:0]  KEY_2   = 8'h55;
    localparam logic [7:0]  C_PROG  = 8'hA0;
    localparam logic [7:0]  C_SID   = 8'hA5;
    localparam logic [7:0]  C_ERPRE = 8'h80;
    localparam logic [7:0]  C_SECT  = 8'h30;
    localparam logic [7:0]  C_BLK   = 8'h50;
    localparam logic [7:0]  C_CHIP  = 8'h10;
    localparam logic [7:0]  C_RESET = 8'hF0;

    localparam int TGL_BIT = 6;
    localparam int INV_BIT = 7;

endpackage

// File: rtl/fos_cmd_gen.sv
// Command write generator: maps an operation kind and a step index to the
// address and data of that bus write. Purely combinational.
// Assumes AW >= 15 and DW >= 8.
module fos_cmd_gen
    import fos_pkg::*;
#(
    parameter int AW = 21,
    parameter int DW = 16
) (
    input  op_e           kind,
    input  logic [2:0]    step,
    input  logic [AW-1:0] tgt_a,
    input  logic [DW-1:0] tgt_d,
    output logic [AW-1:0] wa,
    output logic [DW-1:0] wd,
    output logic          last
);

    logic is_erase;

    // Select address/data for the current step of the unlock sequence.
    always_comb begin
        is_erase = (kind == OP_SECT) || (kind == OP_BLK) || (kind == OP_CHIP);
        last     = is_erase ? (step == 3'd5) : (step == 3'd3);
        wa       = AW'(UNLK_A);
        wd       = DW'(KEY_1);
        case (step)
            3'd0: begin wa = AW'(UNLK_A); wd = DW'(KEY_1); end
            3'd1: begin wa = AW'(UNLK_B); wd = DW'(KEY_2); end
            3'd2: begin
                wa = AW'(UNLK_A);
                wd = is_erase ? DW'(C_ERPRE) :
                     (kind == OP_SID) ? DW'(C_SID) : DW'(C_PROG);
            end
            3'd3: begin
                if (is_erase) begin wa = AW'(UNLK_A); wd = DW'(KEY_1); end
                else          begin wa = tgt_a;       wd = tgt_d;       end
            end
            3'd4: begin wa = AW'(UNLK_B); wd = DW'(KEY_2); end
            3'd5: begin
                if (kind == OP_CHIP)      begin wa = AW'(UNLK_A); wd = DW'(C_CHIP); end
                else if (kind == OP_BLK)  begin wa = tgt_a;       wd = DW'(C_BLK);  end
                else                      begin wa = tgt_a;       wd = DW'(C_SECT); end
            end
            default: begin wa = AW'(UNLK_A); wd = DW'(KEY_1); end
        endcase
    end

endmodule

// File: rtl/fos_poll_eval.sv
// Poll evaluator: decides whether a fresh read is a completion candidate and
// whether two confirming reads uphold it. Purely combinational.
// Assumes DW covers the toggle and inverted status bit positions.
module fos_poll_eval
    import fos_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          use_tgl,
    input  logic          have_prev,
    input  logic [DW-1:0] prev,
    input  logic [DW-1:0] cur,
    input  logic [DW-1:0] expw,
    input  logic [DW-1:0] cand_r,
    input  logic [DW-1:0] c1,
    output logic          cand,
    output logic          conf_ok
);

    // Candidate test for the selected polling method.
    always_comb begin
        if (use_tgl) cand = have_prev && (prev[TGL_BIT] == cur[TGL_BIT]);
        else         cand = (cur[INV_BIT] == expw[INV_BIT]);
    end

    // Confirmation: both extra reads equal and still meeting the test.
    always_comb begin
        if (use_tgl) conf_ok = (c1 == cur) && (c1[TGL_BIT] == cand_r[TGL_BIT]);
        else         conf_ok = (c1 == cur) && (c1[INV_BIT] == expw[INV_BIT]);
    end

endmodule

// File: rtl/fos_tmo.sv
// Polling budget counter: counts cycles spent polling and flags when the
// budget of the current operation kind is reached. Saturates at the budget.
// Assumes the budgets are nonzero.
module fos_tmo
    import fos_pkg::*;
#(
    parameter int T_PROG  = 1250,
    parameter int T_ERASE = 3125000,
    parameter int T_CHIP  = 6250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  op_e  kind,
    output logic hit
);

    localparam int TMAX = (T_CHIP > T_ERASE) ? ((T_CHIP > T_PROG) ? T_CHIP : T_PROG)
                                             : ((T_ERASE > T_PROG) ? T_ERASE : T_PROG);
    localparam int CW   = $clog2(TMAX + 1) + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    // Budget for the operation in progress.
    always_comb begin
        case (kind)
            OP_SECT, OP_BLK: lim = CW'(T_ERASE);
            OP_CHIP:         lim = CW'(T_CHIP);
            default:         lim = CW'(T_PROG);
        endcase
        hit = (cnt >= lim);
    end

    // Cycle counter, cleared when polling begins.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (en && !hit) cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/fos_bus_arb.sv
// Shared bus slot arbiter: grants one flash or SRAM access per slot,
// alternating when both wait, drives the registered bus and captures read
// data at the end of the active cycle. Each side keeps one access in flight
// and must hold its request until its acknowledge.
module fos_bus_arb #(
    parameter int AW = 21,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          f_req,
    input  logic          f_we,
    input  logic [AW-1:0] f_a,
    input  logic [DW-1:0] f_d,
    output logic          f_gnt,
    output logic          f_ack,
    input  logic          s_req,
    input  logic          s_we,
    input  logic [AW-1:0] s_a,
    input  logic [DW-1:0] s_d,
    output logic          s_ack,
    output logic [DW-1:0] rd_q,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    output logic          bus_we,
    output logic          flash_en,
    output logic          sram_en
);

    logic f_busy, s_busy, last_s;
    logic f_ok, s_ok, pick_f, pick_s;

    // Slot choice: alternate between the two sides when both are waiting.
    always_comb begin
        f_ok   = f_req && !f_busy;
        s_ok   = s_req && !s_busy;
        pick_s = s_ok && (!f_ok || !last_s);
        pick_f = f_ok && !pick_s;
        f_gnt  = pick_f;
    end

    // Registered bus drive for the granted slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flash_en  <= 1'b0;
            sram_en   <= 1'b0;
            bus_we    <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
        end else begin
            flash_en  <= pick_f;
            sram_en   <= pick_s;
            bus_we    <= pick_f ? f_we : (pick_s && s_we);
            bus_addr  <= pick_s ? s_a : f_a;
            bus_wdata <= pick_s ? s_d : f_d;
        end
    end

    // Capture read data and acknowledge the owner of the finished slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            f_ack <= 1'b0;
            s_ack <= 1'b0;
        end else begin
            if (flash_en || sram_en) rd_q <= bus_rdata;
            f_ack <= flash_en;
            s_ack <= sram_en;
        end
    end

    // In-flight flags and fairness memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_busy <= 1'b0;
            s_busy <= 1'b0;
            last_s <= 1'b0;
        end else begin
            if (pick_f)     f_busy <= 1'b1;
            else if (f_ack) f_busy <= 1'b0;
            if (pick_s)     s_busy <= 1'b1;
            else if (s_ack) s_busy <= 1'b0;
            if (pick_s)      last_s <= 1'b1;
            else if (pick_f) last_s <= 1'b0;
        end
    end

    // R9
    excl_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(flash_en && sram_en));

    // R9
    sram_ack_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_ack |-> $past(sram_en));

    // R9
    flash_ack_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        f_ack |-> $past(flash_en));

endmodule

// File: rtl/flash_op_seq.sv
// Flash program/erase sequencer (top). Runs one requested operation: unlock
// and command writes, polling with two-read confirmation, final word check,
// and a reset write on budget overrun. SRAM accesses share the bus through
// the slot arbiter. Assumes the host holds sram_req until sram_ack.
module flash_op_seq
    import fos_pkg::*;
#(
    parameter int AW      = 21,
    parameter int DW      = 16,
    parameter int SAW     = 18,
    parameter int T_PROG  = 1250,
    parameter int T_ERASE = 3125000,
    parameter int T_CHIP  = 6250000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           op_start,
    input  logic [2:0]     op_kind,
    input  logic [AW-1:0]  op_addr,
    input  logic [DW-1:0]  op_wdata,
    input  logic           poll_tgl,
    output logic           op_busy,
    output logic           op_done,
    output logic           op_err,
    output logic           op_tmo,
    input  logic           sram_req,
    input  logic           sram_we,
    input  logic [SAW-1:0] sram_addr,
    input  logic [DW-1:0]  sram_wdata,
    output logic           sram_ack,
    output logic [DW-1:0]  sram_rdata,
    output logic [AW-1:0]  bus_addr,
    output logic [DW-1:0]  bus_wdata,
    input  logic [DW-1:0]  bus_rdata,
    output logic           bus_we,
    output logic           flash_en,
    output logic           sram_en
);

    st_e           st;
    op_e           kind_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q, prev_q, r_q, c1_q, expw, rd_q;
    logic [2:0]    step_q;
    logic          tgl_q, hp_q, wait_q;
    logic          f_req, f_we, f_gnt, f_ack, got;
    logic [AW-1:0] f_a, cg_a;
    logic [DW-1:0] f_d, cg_d;
    logic          cg_last, cand, conf_ok, tmo_hit, tmo_clr, tmo_en;
    logic          kind_ok, is_erase;

    fos_cmd_gen #(.AW(AW), .DW(DW)) u_cmd (
        .kind(kind_q), .step(step_q), .tgt_a(addr_q), .tgt_d(data_q),
        .wa(cg_a), .wd(cg_d), .last(cg_last)
    );

    fos_poll_eval #(.DW(DW)) u_poll (
        .use_tgl(tgl_q), .have_prev(hp_q), .prev(prev_q), .cur(rd_q),
        .expw(expw), .cand_r(r_q), .c1(c1_q), .cand(cand), .conf_ok(conf_ok)
    );

    fos_tmo #(.T_PROG(T_PROG), .T_ERASE(T_ERASE), .T_CHIP(T_CHIP)) u_tmo (
        .clk(clk), .rst_n(rst_n), .clr(tmo_clr), .en(tmo_en),
        .kind(kind_q), .hit(tmo_hit)
    );

    fos_bus_arb #(.AW(AW), .DW(DW)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .f_req(f_req), .f_we(f_we), .f_a(f_a), .f_d(f_d),
        .f_gnt(f_gnt), .f_ack(f_ack),
        .s_req(sram_req), .s_we(sram_we), .s_a(AW'(sram_addr)), .s_d(sram_wdata),
        .s_ack(sram_ack), .rd_q(rd_q),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_we(bus_we), .flash_en(flash_en), .sram_en(sram_en)
    );

    // Flash-side bus request and its expected word.
    always_comb begin
        kind_ok    = (op_kind <= 3'd4);
        is_erase   = (kind_q == OP_SECT) || (kind_q == OP_BLK) || (kind_q == OP_CHIP);
        expw       = is_erase ? '1 : data_q;
        f_req      = (st != S_IDLE) && !wait_q;
        f_we       = (st == S_CMD) || (st == S_RST);
        f_a        = (st == S_CMD) ? cg_a : (st == S_RST) ? '0 : addr_q;
        f_d        = (st == S_CMD) ? cg_d : DW'(C_RESET);
        got        = wait_q && f_ack;
        tmo_clr    = (st == S_CMD) && got && cg_last;
        tmo_en     = (st == S_POLL) || (st == S_CONF1) || (st == S_CONF2);
        op_busy    = (st != S_IDLE);
        sram_rdata = rd_q;
    end

    // Operation state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            kind_q  <= OP_PROG;
            addr_q  <= '0;
            data_q  <= '0;
            tgl_q   <= 1'b0;
            step_q  <= '0;
            wait_q  <= 1'b0;
            hp_q    <= 1'b0;
            prev_q  <= '0;
            r_q     <= '0;
            c1_q    <= '0;
            op_done <= 1'b0;
            op_err  <= 1'b0;
            op_tmo  <= 1'b0;
        end else begin
            op_done <= 1'b0;
            op_err  <= 1'b0;
            op_tmo  <= 1'b0;
            if (f_gnt)   wait_q <= 1'b1;
            else if (got) wait_q <= 1'b0;
            case (st)
                S_IDLE: if (op_start && kind_ok) begin
                    kind_q <= op_e'(op_kind);
                    addr_q <= op_addr;
                    data_q <= op_wdata;
                    tgl_q  <= poll_tgl || (op_kind == 3'(OP_SID));
                    step_q <= '0;
                    st     <= S_CMD;
                end
                S_CMD: if (got) begin
                    if (cg_last) begin
                        hp_q <= 1'b0;
                        st   <= S_POLL;
                    end else begin
                        step_q <= step_q + 1'b1;
                    end
                end
                S_POLL: if (got) begin
                    if (tmo_hit)   st <= S_RST;
                    else if (cand) begin r_q <= rd_q; st <= S_CONF1; end
                    else begin prev_q <= rd_q; hp_q <= 1'b1; end
                end
                S_CONF1: if (got) begin
                    c1_q <= rd_q;
                    st   <= tmo_hit ? S_RST : S_CONF2;
                end
                S_CONF2: if (got) begin
                    if (tmo_hit) st <= S_RST;
                    else if (conf_ok) begin
                        op_done <= 1'b1;
                        op_err  <= (rd_q != expw);
                        st      <= S_IDLE;
                    end else begin
                        prev_q <= rd_q;
                        hp_q   <= 1'b1;
                        st     <= S_POLL;
                    end
                end
                S_RST: if (got) begin
                    op_done <= 1'b1;
                    op_tmo  <= 1'b1;
                    st      <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(op_busy) |-> $past(op_start));

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |-> (!op_busy && $past(op_busy)));

    // R7
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |-> !(op_err && op_tmo));

    // R8
    tmo_lim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && op_tmo) |-> tmo_hit);

    // R6
    conf_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !op_tmo) |-> $past(st == S_CONF2));

endmodule

// File: tb/sim_flash_op_seq.sv
// Bench for flash_op_seq: behavioural flash/SRAM model on the shared bus,
// a vector table walked by one loop, then directed tests.
module sim_flash_op_seq;

    localparam int AW = 21, DW = 16, SAW = 18;
    localparam int TP = 40, TE = 80, TC = 120;

    logic clk = 1'b0, rst_n = 1'b0;
    logic op_start = 1'b0, poll_tgl = 1'b0;
    logic [2:0] op_kind = '0;
    logic [AW-1:0] op_addr = '0;
    logic [DW-1:0] op_wdata = '0;
    logic op_busy, op_done, op_err, op_tmo;
    logic sram_req = 1'b0, sram_we = 1'b0;
    logic [SAW-1:0] sram_addr = '0;
    logic [DW-1:0] sram_wdata = '0;
    logic sram_ack;
    logic [DW-1:0] sram_rdata;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata;
    logic bus_we, flash_en, sram_en;

    always #4 clk = ~clk;

    flash_op_seq #(.AW(AW), .DW(DW), .SAW(SAW), .T_PROG(TP), .T_ERASE(TE), .T_CHIP(TC)) u0 (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
        .op_addr(op_addr), .op_wdata(op_wdata), .poll_tgl(poll_tgl),
        .op_busy(op_busy), .op_done(op_done), .op_err(op_err), .op_tmo(op_tmo),
        .sram_req(sram_req), .sram_we(sram_we), .sram_addr(sram_addr),
        .sram_wdata(sram_wdata), .sram_ack(sram_ack), .sram_rdata(sram_rdata),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_we(bus_we), .flash_en(flash_en), .sram_en(sram_en)
    );

    int total = 0, bad = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- device model ----------------
    logic [2:0]    m_kind = '0;
    logic [DW-1:0] m_data = '0, m_fault = '0, m_cell = '1;
    logic [7:0]    m_cnt = '0, m_len_busy = '0;
    int            m_len = 4;
    logic          m_tgl = 1'b0, m_arm = 1'b0, m_started = 1'b0;
    logic [AW-1:0] w_a [8];
    logic [DW-1:0] w_d [8];
    int            w_n = 0;
    logic [DW-1:0] smem [16];
    int            both_en = 0;

    function automatic bit is_er(input logic [2:0] k);
        return (k == 3'd1) || (k == 3'd2) || (k == 3'd3);
    endfunction

    function automatic logic exp7(input logic [2:0] k, input logic [DW-1:0] d);
        return is_er(k) ? 1'b1 : d[7];
    endfunction

    always_comb begin
        bus_rdata = '0;
        if (sram_en) bus_rdata = smem[bus_addr[3:0]];
        else if (m_cnt != 0) begin
            bus_rdata[6] = m_tgl;
            if (m_kind == 3'd4) bus_rdata[7] = m_data[7];
            else                bus_rdata[7] = is_er(m_kind) ? 1'b0 : ~m_data[7];
            if (m_arm && m_cnt <= 8'd9) begin
                bus_rdata[6] = ~m_tgl;
                bus_rdata[7] = exp7(m_kind, m_data);
            end
        end else bus_rdata = m_cell ^ m_fault;
    end

    always @(posedge clk) begin
        if (flash_en && sram_en) both_en <= both_en + 1;
        if (m_cnt != 0) m_cnt <= m_cnt - 8'd1;
        if (sram_en && bus_we) smem[bus_addr[3:0]] <= bus_wdata;
        if (flash_en && !bus_we && m_cnt != 0) begin
            if (m_arm && m_cnt <= 8'd9) m_arm <= 1'b0;
            else m_tgl <= ~m_tgl;
        end
        if (flash_en && bus_we) begin
            if (w_n < 8) begin w_a[w_n] <= bus_addr; w_d[w_n] <= bus_wdata; end
            w_n <= w_n + 1;
            if (w_n + 1 == m_len && !m_started) begin
                m_started <= 1'b1;
                m_cnt     <= m_len_busy;
                m_cell    <= is_er(m_kind) ? '1 : m_data;
            end
        end
    end

    // ---------------- expected command sequence ----------------
    function automatic logic [AW-1:0] ex_a(input logic [2:0] k, input int i, input logic [AW-1:0] a);
        if (!is_er(k)) return (i == 3) ? a : ((i == 1) ? AW'(15'h2AAA) : AW'(15'h5555));
        if (i == 1 || i == 4) return AW'(15'h2AAA);
        if (i == 5) return (k == 3'd3) ? AW'(15'h5555) : a;
        return AW'(15'h5555);
    endfunction

    function automatic logic [DW-1:0] ex_d(input logic [2:0] k, input int i, input logic [DW-1:0] d);
        case (i)
            0, 3: return (!is_er(k) && i == 3) ? d : 16'h00AA;
            1, 4: return 16'h0055;
            2:    return is_er(k) ? 16'h0080 : ((k == 3'd4) ? 16'h00A5 : 16'h00A0);
            default: return (k == 3'd1) ? 16'h0030 : ((k == 3'd2) ? 16'h0050 : 16'h0010);
        endcase
    endfunction

    // ---------------- vectors ----------------
    typedef struct packed {
        logic [2:0]  kind;
        logic        tgl;
        logic        glitch;
        logic [7:0]  busy;
        logic [15:0] data;
        logic [15:0] fault;
        logic        xerr;
        logic        xtmo;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 1'b0, 1'b0, 8'd10,  16'h1234, 16'h0000, 1'b0, 1'b0},
        '{3'd0, 1'b1, 1'b1, 8'd20,  16'hA5C3, 16'h0000, 1'b0, 1'b0},
        '{3'd1, 1'b0, 1'b1, 8'd30,  16'h0000, 16'h0000, 1'b0, 1'b0},
        '{3'd2, 1'b1, 1'b0, 8'd25,  16'h0000, 16'h0000, 1'b0, 1'b0},
        '{3'd3, 1'b0, 1'b0, 8'd60,  16'h0000, 16'h0000, 1'b0, 1'b0},
        '{3'd4, 1'b0, 1'b0, 8'd24,  16'h00FF, 16'h0000, 1'b0, 1'b0},
        '{3'd0, 1'b0, 1'b0, 8'd12,  16'h0F0F, 16'h0001, 1'b1, 1'b0},
        '{3'd1, 1'b1, 1'b0, 8'd18,  16'h0000, 16'h0100, 1'b1, 1'b0},
        '{3'd0, 1'b0, 1'b0, 8'd200, 16'h4321, 16'h0000, 1'b0, 1'b1},
        '{3'd3, 1'b1, 1'b0, 8'd0,   16'h0000, 16'h0000, 1'b0, 1'b0}
    };

    logic seen_done, seen_err, seen_tmo, busy_at_done;

    task automatic launch(input logic [2:0] k, input logic t, input logic g,
                          input logic [7:0] b, input logic [DW-1:0] d,
                          input logic [DW-1:0] f, input logic [AW-1:0] a);
        while (m_cnt != 0) @(negedge clk);
        @(negedge clk);
        m_kind = k; m_data = d; m_fault = f; m_len_busy = b; m_arm = g;
        m_len = is_er(k) ? 6 : 4; m_started = 1'b0; w_n = 0;
        op_kind = k; poll_tgl = t; op_wdata = d; op_addr = a; op_start = 1'b1;
        @(negedge clk);
        op_start = 1'b0;
    endtask

    task automatic wait_done();
        seen_done = 1'b0;
        while (!seen_done) begin
            @(negedge clk);
            if (op_done) begin
                seen_done = 1'b1; seen_err = op_err; seen_tmo = op_tmo;
                busy_at_done = (m_cnt != 0);
            end
        end
    endtask

    task automatic check_seq(input logic [2:0] k, input logic [AW-1:0] a,
                             input logic [DW-1:0] d, input logic tmo, input string tag);
        int n;
        bit ok;
        n = (is_er(k) ? 6 : 4) + (tmo ? 1 : 0);
        chk(w_n == n, {tag, " write count"}, w_n, n);
        ok = 1'b1;
        for (int i = 0; i < (is_er(k) ? 6 : 4); i++)
            if (w_a[i] != ex_a(k, i, a) || w_d[i] != ex_d(k, i, d)) ok = 1'b0;
        chk(ok, {tag, " command words"}, int'(w_d[0]), int'(ex_d(k, 0, d)));
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 60000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 60000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) smem[i] = '0;
        repeat (4) @(negedge clk);
        // R11 reset state
        chk(!op_busy && !op_done, "R11 busy/done after reset", {op_busy, op_done}, 0);
        chk(!flash_en && !sram_en, "R11 enables after reset", {flash_en, sram_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector loop: R1 R2 R3 R4 R5 R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            vec_t t;
            string tg;
            t = VECS[v];
            tg = $sformatf("v%0d %s", v, (t.kind == 3'd4) ? "R3" : (is_er(t.kind) ? "R2" : "R1"));
            launch(t.kind, t.tgl, t.glitch, t.busy, t.data, t.fault, AW'(21'h1A000 + v));
            wait_done();
            check_seq(t.kind, AW'(21'h1A000 + v), t.data, t.xtmo, tg);
            chk(seen_err == t.xerr, $sformatf("v%0d R7 err flag", v), seen_err, t.xerr);
            chk(seen_tmo == t.xtmo, $sformatf("v%0d R8 tmo flag", v), seen_tmo, t.xtmo);
            if (t.xtmo) begin
                chk(w_d[4] == 16'h00F0, $sformatf("v%0d R8 reset write", v), w_d[4], 16'h00F0);
            end else begin
                chk(!busy_at_done, $sformatf("v%0d R6 %s done while busy", v,
                    (t.tgl || t.kind == 3'd4) ? "R4" : "R5"), busy_at_done, 0);
            end
        end

        // R10 invalid kind ignored
        while (m_cnt != 0) @(negedge clk);
        op_kind = 3'd7; op_start = 1'b1;
        @(negedge clk);
        op_start = 1'b0;
        repeat (3) @(negedge clk);
        chk(!op_busy && !flash_en, "R10 invalid kind ignored", op_busy, 0);

        // R9 SRAM traffic during a chip erase, R10 start ignored while busy
        launch(3'd3, 1'b1, 1'b0, 8'd100, 16'h0, 16'h0, AW'(21'h0));
        op_kind = 3'd0; op_start = 1'b1;
        @(negedge clk);
        op_start = 1'b0;
        repeat (20) @(negedge clk);
        sram_req = 1'b1; sram_we = 1'b1; sram_addr = SAW'(5); sram_wdata = 16'hBEEF;
        while (!sram_ack) @(negedge clk);
        sram_req = 1'b0;
        @(negedge clk);
        sram_req = 1'b1; sram_we = 1'b0; sram_addr = SAW'(5);
        while (!sram_ack) @(negedge clk);
        chk(sram_rdata == 16'hBEEF, "R9 SRAM read during erase", sram_rdata, 16'hBEEF);
        chk(op_busy, "R9 flash still busy at SRAM ack", op_busy, 1);
        sram_req = 1'b0;
        wait_done();
        check_seq(3'd3, AW'(21'h0), 16'h0, 1'b0, "R10 chip erase unaffected by start");
        @(negedge clk);
        chk(!op_busy, "R10 no second op", op_busy, 0);
        chk(both_en == 0, "R9 enables exclusive", both_en, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule